// File: doc/BRIEF.md
# Flash Ready-Poll Engine

After a reset, page read, program or erase command has been sent to a serial NAND flash device, the device stays busy for a while. This block waits out that period. A one-cycle `start` pulse, together with a two-bit operation class, launches a wait. The engine first sits out an initial delay chosen by the class. It then asks the frame engine for single-byte reads of the device status register, spaced by a class-specific poll interval, until a reply shows the device idle or the overall time budget runs out. It reports the last status byte, its decoded failure flags and error-correction result, and whether the wait ended on timeout.

Time is kept in microseconds. Two prescalers divide the system clock by `CLKS_PER_US`: one paces the delays and one measures the elapsed time since `start`. Every delay and the timeout are parameters in microseconds, so a bench can run scaled-down values. The frame engine that shifts bytes on the serial bus is a separate block.

The request channel is valid/ready. `req_valid` with `req_addr` is held steady until `req_ready` accepts it, and the frame engine may stall for any number of cycles. The reply channel is valid/ready as well. `rsp_ready` is high only while a reply is awaited. A `rsp_valid` seen while `rsp_ready` is low is not consumed and has no effect.

Top module: `nrp_ready_poller`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid`, `rsp_ready`, `timed_out`, `erase_fail`, `prog_fail`, `ecc_code` and `status` are all zero.
- R2: A `start` sampled while idle raises `busy` in the next cycle. `req_valid` first rises INIT×`CLKS_PER_US` cycles after that edge, where INIT in µs follows `op_class`: 0 = reset 5, 1 = page read 6, 2 = program 75, 3 = erase 250.
- R3: Every request carries `req_addr` = 0xC0. `req_valid` and `req_addr` hold until `req_ready`. `rsp_ready` is high only from request acceptance until a reply is taken, and never together with `req_valid`.
- R4: A reply with bit 0 set, taken before the timeout, leads to the next `req_valid` POLL×`CLKS_PER_US` cycles after the reply edge. POLL in µs is 5 for reset, 5 for read, 15 for program and 50 for erase.
- R5: A reply with bit 0 clear ends the wait. In the next cycle `done` pulses for one cycle, `busy` falls, `status` equals the reply byte and `timed_out` is 0.
- R6: `erase_fail` equals bit 2 of `status` and `prog_fail` equals bit 3 of `status`.
- R7: `ecc_code` is taken from `status` bits 5:4. Raw 0 gives 0 (clean), raw 1 gives 1 (corrected), and raw 2 or raw 3 (3 is reserved) gives 2 (uncorrectable).
- R8: A busy reply taken more than `TIMEOUT_US`×`CLKS_PER_US` cycles after the start edge ends the wait with `done`, `timed_out` = 1 and `status` = that byte.
- R9: `done` pulses exactly once per wait. `status`, `timed_out` and the decoded flags change only with `done`, so they stay stable across a later `start`.
- R10: A `start` sampled while `busy` is ignored and alters neither the class nor the timing.
- R11: A `rsp_valid` while `rsp_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a wait (pulse) |
| op_class | input | 2 | 0 reset, 1 read, 2 program, 3 erase |
| busy | output | 1 | A wait is in progress |
| req_valid | output | 1 | Status-read request valid |
| req_ready | input | 1 | Frame engine accepts request |
| req_addr | output | 8 | Feature register address to read |
| rsp_valid | input | 1 | Status reply valid |
| rsp_ready | output | 1 | Engine takes a reply |
| rsp_data | input | 8 | Status byte returned |
| done | output | 1 | One-cycle end-of-wait pulse |
| status | output | 8 | Last status byte of the finished wait |
| timed_out | output | 1 | Finished wait ended on timeout |
| erase_fail | output | 1 | Decoded erase failure |
| prog_fail | output | 1 | Decoded program failure |
| ecc_code | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |

## Verification
The bench drives all four classes and checks the exact cycle of each request. A design that restarts the wrong prescaler, or that takes the poll interval from `op_class` instead of the latched class, places requests off by cycles. The bench also stalls `req_ready` and delays replies, which catches a request that drops early or a reply that is taken twice. Status bytes with raw ECC values 1, 2 and 3 and with both failure bits expose a decoder that passes the reserved code through or swaps bit positions. A wait that never sees an idle reply must end on timeout at the right reply. Spurious `start` and `rsp_valid` pulses in the middle of a wait reveal an engine that restarts or finishes early.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  typedef enum logic [1:0] {
    OPC_RESET = 2'd0,
    OPC_READ  = 2'd1,
    OPC_PROG  = 2'd2,
    OPC_ERASE = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_LOST  = 2'd2
  } ecc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_RESP
  } state_e;

  localparam int BUSY_BIT  = 0;
  localparam int ERS_BIT   = 2;
  localparam int PGM_BIT   = 3;
  localparam int ECC_LO    = 4;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nrp_us_tick.sv
module nrp_us_tick #(
  parameter int CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (restart)        pre_q <= '0;
    else if (pre_q == LAST)  pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/nrp_countdown.sv
module nrp_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = tick && (cnt_q == W'(1));
endmodule

// File: rtl/nrp_status_decode.sv
module nrp_status_decode
  import nrp_pkg::*;
(
  input  logic [7:0] stat,
  output logic       erase_fail,
  output logic       prog_fail,
  output ecc_e       ecc
);
  logic [1:0] raw;

  assign raw        = stat[ECC_LO+1:ECC_LO];
  assign erase_fail = stat[ERS_BIT];
  assign prog_fail  = stat[PGM_BIT];

  always_comb begin
    case (raw)
      2'd0:    ecc = ECC_CLEAN;
      2'd1:    ecc = ECC_FIXED;
      default: ecc = ECC_LOST;   // 2 and reserved 3
    endcase
  end
endmodule

// File: rtl/nrp_ready_poller.sv
module nrp_ready_poller
  import nrp_pkg::*;
#(
  parameter int         CLKS_PER_US = 125,
  parameter int         RST_INIT_US = 5,
  parameter int         RST_POLL_US = 5,
  parameter int         RD_INIT_US  = 6,
  parameter int         RD_POLL_US  = 5,
  parameter int         PGM_INIT_US = 75,
  parameter int         PGM_POLL_US = 15,
  parameter int         ERS_INIT_US = 250,
  parameter int         ERS_POLL_US = 50,
  parameter int         TIMEOUT_US  = 400000,
  parameter logic [7:0] STATUS_ADDR = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_class,
  output logic       busy,
  output logic       req_valid,
  input  logic       req_ready,
  output logic [7:0] req_addr,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic [7:0] rsp_data,
  output logic       done,
  output logic [7:0] status,
  output logic       timed_out,
  output logic       erase_fail,
  output logic       prog_fail,
  output logic [1:0] ecc_code
);
  localparam int MAX_INIT = imax(imax(RST_INIT_US, RD_INIT_US), imax(PGM_INIT_US, ERS_INIT_US));
  localparam int MAX_POLL = imax(imax(RST_POLL_US, RD_POLL_US), imax(PGM_POLL_US, ERS_POLL_US));
  localparam int DLY_W    = $clog2(imax(MAX_INIT, MAX_POLL) + 1);
  localparam int EL_W     = $clog2(TIMEOUT_US + 1);
  localparam int N_TICK   = 2;   // 0: delay pacing, 1: elapsed time
  localparam int TK_DLY   = 0;
  localparam int TK_EL    = 1;

  state_e           st_q;
  logic [1:0]       cls_q;
  logic [7:0]       status_q;
  logic             timeout_q;
  logic             done_q;
  logic [EL_W-1:0]  elapsed_q;

  logic [N_TICK-1:0] tk_restart;
  logic [N_TICK-1:0] tk;
  logic              take_start;
  logic              take_rsp;
  logic              rsp_busy;
  logic              late;
  logic              finish;
  logic              dly_load;
  logic              dly_expire;
  logic [DLY_W-1:0]  init_sel;
  logic [DLY_W-1:0]  poll_sel;
  logic [DLY_W-1:0]  dly_val;
  ecc_e              ecc_w;

  assign take_start = (st_q == ST_IDLE) && start;
  assign take_rsp   = (st_q == ST_RESP) && rsp_valid;
  assign rsp_busy   = rsp_data[BUSY_BIT];
  assign late       = (elapsed_q >= EL_W'(TIMEOUT_US));
  assign finish     = take_rsp && (!rsp_busy || late);
  assign dly_load   = take_start || (take_rsp && rsp_busy && !late);
  assign dly_val    = take_start ? init_sel : poll_sel;

  // initial delay follows the incoming class; poll interval the latched one
  always_comb begin
    case (op_class_e'(op_class))
      OPC_RESET: init_sel = DLY_W'(RST_INIT_US);
      OPC_READ:  init_sel = DLY_W'(RD_INIT_US);
      OPC_PROG:  init_sel = DLY_W'(PGM_INIT_US);
      default:   init_sel = DLY_W'(ERS_INIT_US);
    endcase
    case (op_class_e'(cls_q))
      OPC_RESET: poll_sel = DLY_W'(RST_POLL_US);
      OPC_READ:  poll_sel = DLY_W'(RD_POLL_US);
      OPC_PROG:  poll_sel = DLY_W'(PGM_POLL_US);
      default:   poll_sel = DLY_W'(ERS_POLL_US);
    endcase
  end

  assign tk_restart[TK_DLY] = dly_load;
  assign tk_restart[TK_EL]  = take_start;

  for (genvar g = 0; g < N_TICK; g++) begin : g_tick
    nrp_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tk_restart[g]),
      .tick    (tk[g])
    );
  end

  nrp_countdown #(.W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_val),
    .tick     (tk[TK_DLY]),
    .expire   (dly_expire)
  );

  // saturating microseconds since start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  elapsed_q <= '0;
    else if (take_start)         elapsed_q <= '0;
    else if (tk[TK_EL] && !late) elapsed_q <= elapsed_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cls_q     <= 2'd0;
      status_q  <= 8'h00;
      timeout_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            cls_q <= op_class;
            st_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dly_expire) st_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (req_ready) st_q <= ST_RESP;
        end
        ST_RESP: begin
          if (finish) begin
            status_q  <= rsp_data;
            timeout_q <= rsp_busy;
            done_q    <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (take_rsp) begin
            st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  nrp_status_decode u_dec (
    .stat       (status_q),
    .erase_fail (erase_fail),
    .prog_fail  (prog_fail),
    .ecc        (ecc_w)
  );

  assign busy      = (st_q != ST_IDLE);
  assign req_valid = (st_q == ST_ISSUE);
  assign req_addr  = STATUS_ADDR;
  assign rsp_ready = (st_q == ST_RESP);
  assign done      = done_q;
  assign status    = status_q;
  assign timed_out = timeout_q;
  assign ecc_code  = ecc_w;
endmodule

// File: rtl/nrp_ready_poller_chk.sv
module nrp_ready_poller_chk #(
  parameter logic [7:0] STATUS_ADDR = 8'hC0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_addr,
  input logic       rsp_ready,
  input logic       done,
  input logic [7:0] status,
  input logic       timed_out,
  input logic [1:0] ecc_code
);
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_req_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr == STATUS_ADDR));

  assert_chan_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ready_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timed_out) |-> !status[0]);

  assert_ecc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_code != 2'b11);

  assert_timeout_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timed_out) |-> status[0]);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(status) && $stable(timed_out)));
endmodule

bind nrp_ready_poller nrp_ready_poller_chk #(.STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_ready (rsp_ready),
  .done      (done),
  .status    (status),
  .timed_out (timed_out),
  .ecc_code  (ecc_code)
);

// File: tb/sim_nrp_ready_poller.sv
`timescale 1ns/1ps
module sim_nrp_ready_poller;
  localparam int CPU   = 2;
  localparam int TO_US = 700;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op_class = 2'd0;
  logic       req_ready = 1'b0;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic       busy, req_valid, rsp_ready, done, timed_out, erase_fail, prog_fail;
  logic [7:0] req_addr, status;
  logic [1:0] ecc_code;

  always #4 clk = ~clk;   // 125 MHz

  nrp_ready_poller #(.CLKS_PER_US(CPU), .TIMEOUT_US(TO_US)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
    .busy(busy), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .status(status), .timed_out(timed_out),
    .erase_fail(erase_fail), .prog_fail(prog_fail), .ecc_code(ecc_code)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;
  int done_cnt = 0;

  // ---------------- reference model ----------------
  int         m_st = 0;   // 0 idle, 1 waiting, 2 requesting, 3 awaiting reply
  int         m_wait, m_t;
  int         m_cls;
  bit         m_done = 1'b0;
  logic [7:0] m_status = 8'h00;
  bit         m_to = 1'b0;

  function automatic int init_us(input int c);
    case (c) 0: return 5; 1: return 6; 2: return 75; default: return 250; endcase
  endfunction
  function automatic int poll_us(input int c);
    case (c) 0: return 5; 1: return 5; 2: return 15; default: return 50; endcase
  endfunction
  function automatic logic [1:0] exp_ecc(input logic [7:0] s);
    case (s[5:4]) 2'd0: return 2'd0; 2'd1: return 2'd1; default: return 2'd2; endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_status = 8'h00; m_to = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (start) begin
             m_cls = int'(op_class); m_wait = init_us(m_cls) * CPU; m_t = 0; m_st = 1;
           end
        1: begin m_t++; m_wait--; if (m_wait == 0) m_st = 2; end
        2: begin m_t++; if (req_ready) m_st = 3; end
        default: begin
          m_t++;
          if (rsp_valid) begin
            if (!rsp_data[0] || m_t > TO_US * CPU) begin
              m_status = rsp_data; m_to = rsp_data[0]; m_done = 1; m_st = 0;
            end else begin
              m_wait = poll_us(m_cls) * CPU; m_st = 1;
            end
          end
        end
      endcase
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R2 R10 busy", int'(busy), int'(m_st != 0));
      chk("R2 R4 req_valid", int'(req_valid), int'(m_st == 2));
      if (m_st == 2) chk("R3 req_addr", int'(req_addr), 8'hC0);
      chk("R3 R11 rsp_ready", int'(rsp_ready), int'(m_st == 3));
      chk("R5 R9 done", int'(done), int'(m_done));
      chk("R5 R9 status", int'(status), int'(m_status));
      chk("R8 timed_out", int'(timed_out), int'(m_to));
      chk("R6 erase_fail", int'(erase_fail), int'(m_status[2]));
      chk("R6 prog_fail", int'(prog_fail), int'(m_status[3]));
      chk("R7 ecc_code", int'(ecc_code), int'(exp_ecc(m_status)));
      if (done) done_cnt++;
    end
  end

  // ---------------- frame engine stand-in ----------------
  task automatic run_wait(input logic [1:0] cls, input int nbusy, input logic [7:0] bbyte,
                          input logic [7:0] fin, input int rdy_lat, input int rsp_lat,
                          input bit inject);
    int base = done_cnt;
    int n = 0;
    @(negedge clk); start = 1'b1; op_class = cls;
    @(negedge clk); start = 1'b0; op_class = 2'd0;
    if (inject) begin
      repeat (3) @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 8'h00;         // R11: nobody asked for this
      start = 1'b1; op_class = 2'd3;              // R10: start during a wait
      @(negedge clk);
      rsp_valid = 1'b0; start = 1'b0; op_class = 2'd0;
    end
    while (done_cnt == base) begin
      @(negedge clk);
      if (done_cnt != base) break;
      if (req_valid) begin
        repeat (rdy_lat) @(negedge clk);
        req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = (n < nbusy) ? bbyte : fin;
        n++;
        @(negedge clk); rsp_valid = 1'b0;
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is still applied
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset req_valid", int'(req_valid), 0);
    chk("R1 reset rsp_ready", int'(rsp_ready), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset flags", int'({timed_out, erase_fail, prog_fail, ecc_code}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_wait(2'd1, 2, 8'h01, 8'h00, 0, 0, 1'b0);      // read, two busy polls
    run_wait(2'd0, 0, 8'h01, 8'h14, 3, 0, 1'b0);      // reset, stalled request, ECC 1 + erase fail
    run_wait(2'd2, 3, 8'h11, 8'h28, 1, 2, 1'b1);      // program, R10/R11 injection, ECC 2 + program fail
    run_wait(2'd3, 1, 8'h01, 8'h30, 0, 1, 1'b0);      // erase, reserved ECC 3
    run_wait(2'd1, 0, 8'h01, 8'h0C, 0, 0, 1'b0);      // both failure bits
    run_wait(2'd0, 1000000, 8'h21, 8'h00, 0, 0, 1'b0); // R8: never ready
    run_wait(2'd1, 1, 8'h01, 8'h00, 2, 3, 1'b0);      // timeout flag clears
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=no-finish expected=all waits done");
    finish_run();
  end
endmodule